// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped watchdog with a restart window. A 12-bit down-counter steps once per slow tick enable, which is nominally 256 Hz, so 256 ticks make one second. Software must restart the counter before it expires. A restart only counts as valid once the counter has fallen to a programmed window threshold or below. If the counter expires, or if software restarts it too early, the block records a fault. Depending on how it is configured, it then raises a fault interrupt, requests a system reset, or does both.

The configuration register takes exactly one write after reset; later writes are dropped. The restart command only takes effect when it carries an 8-bit key. Two flags in a status word report what went wrong, and reading that word clears them. The counter stops while the block is disabled. It also stops while the debug-halt or idle-halt input is active, if the matching configuration bit allows that halt.

Top module: `window_watchdog`

## Requirements
- R1: After reset, the configuration register reads 0x3FFF2FFF, the status word reads 0, both outputs are low, and the counter holds 0xFFF.
- R2: The configuration register takes only the first write after reset. Every later write leaves its value unchanged.
- R3: The register map uses byte offsets. The command register is at 0x0 and reads 0. The configuration register is at 0x4. The status word is at 0x8.
  - Configuration register fields: bits 11:0 are the reload value and bits 27:16 are the window threshold. Bit 12 enables the interrupt, bit 13 enables the reset request, bit 14 selects processor-only reset, and bit 15 disables the block. Bit 28 allows halt in debug and bit 29 allows halt in idle.
  - Bits 31:30 of the configuration register are not stored and read 0.
- R4: A counted tick that arrives while the counter is 0 sets the underflow flag and loads the counter with the reload value. Otherwise a counted tick decrements the counter.
- R5: A write to the command register with 0xA5 in bits 31:24 and bit 0 set is a restart, and it loads the counter with the reload value. A restart made while the counter is at or below the window threshold raises no flag.
- R6: A restart made while the counter is above the window threshold sets the error flag, and the counter is still reloaded.
- R7: A command write with any other key has no effect on the counter or on the flags.
- R8: The interrupt is high while bit 12 is set and either flag is set. The reset request is high while bit 13 is set and either flag is set.
- R9: The status word holds the underflow flag in bit 0 and the error flag in bit 1. A read of the status word clears both flags. If a new event arrives in the same cycle as the read, the new event is kept.
- R10: Ticks are not counted while bit 15 is set, while the debug halt is active with bit 28 set, or while the idle halt is active with bit 29 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of the status word clears the flags |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| tick_en | input | 1 | Slow tick enable, one clock wide |
| dbg_halt | input | 1 | Debug halt indication |
| idle_halt | input | 1 | Idle halt indication |
| rst_req | output | 1 | Reset request |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The counter is never visible at the ports, so the window edges have to be reached by counting ticks exactly from a known reload.

Before the configuration can be written, the counter sits at 0xFFF. The bench uses this to provoke the first error: it makes an early restart, which also loads a small reload value. From that reload it steps to exactly the threshold and exactly one tick above it, and it makes a restart at each of those points.

To confirm that a halt or the disable bit froze the counter, the bench applies more ticks than would otherwise cause an underflow. It then checks that the underflow appears on precisely the tick that the reload value predicts.

// File: rtl/window_watchdog.sv
module window_watchdog #(
  parameter int          CNT_W  = 12,
  parameter int          ADDR_W = 4,
  parameter logic [7:0]  KEY    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              tick_en,
  input  logic              dbg_halt,
  input  logic              idle_halt,
  output logic              rst_req,
  output logic              fault_irq
);
  localparam logic [29:0]       CFG_RST  = 30'h3FFF_2FFF;
  localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8);

  logic [29:0]      cfg_q;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unf_q, err_q;

  wire [CNT_W-1:0] reload = cfg_q[CNT_W-1:0];
  wire [CNT_W-1:0] window = cfg_q[16 +: CNT_W];
  wire irq_en  = cfg_q[12];
  wire rst_en  = cfg_q[13];
  wire frozen  = cfg_q[15] | (dbg_halt & cfg_q[28]) | (idle_halt & cfg_q[29]);

  wire cmd_wr     = bus_we && bus_addr == OFS_CMD;
  wire restart    = cmd_wr && bus_wdata[31:24] == KEY && bus_wdata[0];
  wire count_tick = tick_en && !frozen;
  wire early      = restart && cnt_q > window;
  wire expiry     = count_tick && cnt_q == '0 && !restart;
  wire stat_clr   = bus_re && bus_addr == OFS_STAT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RST;
      locked_q <= 1'b0;
    end else if (bus_we && bus_addr == OFS_CFG && !locked_q) begin
      cfg_q    <= bus_wdata[29:0];
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '1;
    else if (restart)
      cnt_q <= reload;
    else if (count_tick)
      cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unf_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      unf_q <= (unf_q && !stat_clr) || expiry;
      err_q <= (err_q && !stat_clr) || early;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CFG:  bus_rdata = {2'b00, cfg_q};
      OFS_STAT: bus_rdata = {30'd0, err_q, unf_q};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign fault_irq = irq_en && (unf_q || err_q);
  assign rst_req   = rst_en && (unf_q || err_q);

  a_r2_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cfg_q));
  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> unf_q && cnt_q == $past(reload));
  a_r6_early_err: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> err_q);
  a_r7_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[31:24] != KEY && !count_tick) |=> $stable(cnt_q));
  a_r8_reset_out: assert property (@(posedge clk) disable iff (!rst_n)
    (early && rst_en) |=> rst_req);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !expiry) |=> !unf_q);
  a_r10_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_tick && !restart) |=> $stable(cnt_q));
endmodule

// File: tb/window_watchdog_bench.sv
module window_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0, dbg_halt = 1'b0, idle_halt = 1'b0;
  logic        rst_req, fault_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_val[$];
  string       exp_tag[$];

  always #5 clk = ~clk;

  window_watchdog u_window_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .dbg_halt(dbg_halt), .idle_halt(idle_halt),
    .rst_req(rst_req), .fault_irq(fault_irq));

  always @(negedge clk) begin
    #2;
    if (bus_re && exp_val.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_val.pop_front();
      t = exp_tag.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic expect_read(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_val.push_back(e);
    exp_tag.push_back(t);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic check_pin(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    apply_reset();
    // R1 reset state, R3 map
    expect_read(4'h4, 32'h3FFF2FFF, "R1 cfg reset");
    expect_read(4'h8, 32'h0, "R1 status reset");
    expect_read(4'h0, 32'h0, "R3 cmd reads zero");
    check_pin(fault_irq, 1'b0, "R1 irq low");
    check_pin(rst_req, 1'b0, "R1 rst_req low");

    // R3 top bits dropped; R2 one write only
    wr(4'h4, 32'hF004100A);
    expect_read(4'h4, 32'h3004100A, "R3 cfg fields");
    wr(4'h4, 32'h00000000);
    expect_read(4'h4, 32'h3004100A, "R2 second write ignored");

    // R6 early restart at 0xFFF > 4
    wr(4'h0, 32'hA5000001);
    check_pin(fault_irq, 1'b1, "R8 irq on error");
    check_pin(rst_req, 1'b0, "R8 no reset when disabled");
    expect_read(4'h8, 32'h2, "R6 error flag");
    expect_read(4'h8, 32'h0, "R9 cleared on read");
    check_pin(fault_irq, 1'b0, "R8 irq drops after clear");

    // R5 restart exactly at the threshold (cnt 10 -> 4)
    ticks(6);
    wr(4'h0, 32'hA5000001);
    expect_read(4'h8, 32'h0, "R5 in-window restart");

    // R7 wrong key, then R4 underflow timing
    ticks(6);
    wr(4'h0, 32'h5A000001);
    expect_read(4'h8, 32'h0, "R7 bad key no flag");
    ticks(4);
    expect_read(4'h8, 32'h0, "R7 R4 counter at zero, no event yet");
    ticks(1);
    check_pin(fault_irq, 1'b1, "R8 irq on underflow");
    expect_read(4'h8, 32'h1, "R4 underflow flag");
    expect_read(4'h8, 32'h0, "R9 underflow cleared");

    // R6 one tick above threshold (cnt 10 -> 5)
    ticks(5);
    wr(4'h0, 32'hA5000001);
    expect_read(4'h8, 32'h2, "R6 restart one above window");

    // R10 halts freeze the counter (cnt 10)
    dbg_halt = 1'b1;
    ticks(20);
    dbg_halt = 1'b0;
    idle_halt = 1'b1;
    ticks(15);
    idle_halt = 1'b0;
    expect_read(4'h8, 32'h0, "R10 halted no underflow");
    ticks(10);
    expect_read(4'h8, 32'h0, "R10 R4 count resumed at zero");
    ticks(1);
    expect_read(4'h8, 32'h1, "R10 R4 underflow after resume");

    // second configuration: disabled, reset request enabled
    apply_reset();
    expect_read(4'h4, 32'h3FFF2FFF, "R1 cfg after second reset");
    wr(4'h4, 32'h0000A00A);
    wr(4'h0, 32'hA5000001);
    check_pin(rst_req, 1'b1, "R8 reset request on error");
    check_pin(fault_irq, 1'b0, "R8 irq masked");
    expect_read(4'h8, 32'h2, "R6 error with window zero");
    check_pin(rst_req, 1'b0, "R9 R8 request drops after clear");
    ticks(30);
    expect_read(4'h8, 32'h0, "R10 disabled freezes counter");
    check_pin(rst_req, 1'b0, "R10 no request while disabled");

    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule